// File: doc/BRIEF.md
# Redundant Binary Digit Adder

This block adds two signed numbers held in redundant binary form and returns their sum in the same form, one digit wider than the operands. Each digit is a pair of bits, a plus bit and a minus bit, and its value is the plus bit minus the minus bit. Because every digit may be -1, 0 or +1, a sum can be formed without a carry that ripples across the word. The adder therefore takes the same time at any width. It is meant to sit inside a partial-product reduction tree, where many such sums are stacked in layers.

The sum is formed in two steps. In the first step, every digit position looks at its own two operand digits. It also reads a look-back flag computed from the two digits one place lower. From these it forms an interim sum digit and a transfer digit. In the second step, every position merges its interim digit with the transfer that arrives from the position below. The look-back flag is chosen so that this merge never has to pass anything further up. The result can come straight from the merge logic, or it can be held in an optional output register that has a synchronous active-high reset.

Top module: `rb_adder`

## Requirements
- R1: A digit is a pair (plus, minus) with value plus minus minus. (1,0) is +1, (0,1) is -1 and (0,0) is 0. Operand digits are never (1,1). Bit k of each operand vector holds digit k, with weight 2^k.
- R2: No result digit is ever (1,1).
- R3: The result has N_DIGITS+1 digits. Digit k has weight 2^k. The value of the result equals the value of operand A plus the value of operand B, for every legal operand pair.
- R4: When both digits at a position are +1, the transfer is +1 and the interim digit is 0. When both are -1, the transfer is -1 and the interim digit is 0. When the pair is 0 and 0, or +1 and -1, both are 0. So all-(+1) plus all-(+1) gives result digit 0 = 0 and digits 1..N_DIGITS = +1. All-(-1) plus all-(-1) gives the mirror image. All-(+1) plus all-(-1) gives all zeros.
- R5: When a position holds one +1 and one 0, and the look-back flag is 1, the transfer is +1 and the interim digit is -1. When the flag is 0, the transfer is 0 and the interim digit is +1. The flag is 1 exactly when neither digit one place lower is -1.
- R6: When a position holds one -1 and one 0, and the flag is 1, the transfer is 0 and the interim digit is -1. When the flag is 0, the transfer is -1 and the interim digit is +1.
- R7: At digit 0 the flag is taken as 1 and the incoming transfer is 0. The transfer out of the top position becomes result digit N_DIGITS.
- R8: An interim digit and the transfer arriving from below never have the same nonzero sign. The merge therefore never produces a carry.
- R9: With REG_OUT=1, the result appears one clock after the operands. While reset is high, the registered result is cleared to all (0,0) digits. With REG_OUT=0, the result follows the operands combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_pos | input | N_DIGITS | Plus bits of operand A |
| a_neg | input | N_DIGITS | Minus bits of operand A |
| b_pos | input | N_DIGITS | Plus bits of operand B |
| b_neg | input | N_DIGITS | Minus bits of operand B |
| sum_pos | output | N_DIGITS+1 | Plus bits of the result |
| sum_neg | output | N_DIGITS+1 | Minus bits of the result |

## Verification
The assertions are checked on every cycle. They cover the following:
- The operands are legal.
- No result digit is ever (1,1).
- The combinational result has the right value.
- An interim digit never collides with the transfer that arrives from below.
- Two +1 digits at the top position raise the top result digit.
- Reset clears the register.

A correct value alone cannot show that the look-back flag picks the right case. A wrong flag can still give the right value with different digits. The bench therefore compares exact digit patterns on directed operands that force each case with the flag at 0 and at 1. It also runs exhaustive operands at a small width and random operands at the default width, and checks the one-cycle latency.

// File: rtl/rbadd_pkg.sv
package rbadd_pkg;

    typedef struct packed {
        logic pos;
        logic neg;
    } rb_digit_t;

    typedef enum logic [2:0] {
        PAIR_CANCEL   = 3'd0,
        PAIR_BOTH_POS = 3'd1,
        PAIR_BOTH_NEG = 3'd2,
        PAIR_ONE_POS  = 3'd3,
        PAIR_ONE_NEG  = 3'd4
    } pair_case_e;

    localparam rb_digit_t RB_ZERO = '{pos: 1'b0, neg: 1'b0};
    localparam rb_digit_t RB_PLUS = '{pos: 1'b1, neg: 1'b0};
    localparam rb_digit_t RB_MINUS = '{pos: 1'b0, neg: 1'b1};

    // Sort a pair of legal digits into one of the five addition cases.
    function automatic pair_case_e classify_pair(rb_digit_t x, rb_digit_t y);
        logic [1:0] n_pos;
        logic [1:0] n_neg;
        n_pos = {1'b0, x.pos} + {1'b0, y.pos};
        n_neg = {1'b0, x.neg} + {1'b0, y.neg};
        if (n_pos == 2'd2)                         return PAIR_BOTH_POS;
        else if (n_neg == 2'd2)                    return PAIR_BOTH_NEG;
        else if (n_pos == 2'd1 && n_neg == 2'd0)   return PAIR_ONE_POS;
        else if (n_neg == 2'd1 && n_pos == 2'd0)   return PAIR_ONE_NEG;
        else                                       return PAIR_CANCEL;
    endfunction

    // Look-back flag: high when no digit of the lower pair is negative.
    function automatic logic no_negative(rb_digit_t x, rb_digit_t y);
        return ~(x.neg | y.neg);
    endfunction

endpackage

// File: rtl/rb_lookback.sv
module rb_lookback
    import rbadd_pkg::*;
#(
    parameter bit IS_LSB = 1'b0
) (
    input  rb_digit_t low_a,
    input  rb_digit_t low_b,
    output logic      flag
);
    generate
        if (IS_LSB) begin : g_lsb
            logic unused_ok;
            assign unused_ok = ^{low_a, low_b};
            assign flag = 1'b1;
        end else begin : g_mid
            assign flag = no_negative(low_a, low_b);
        end
    endgenerate
endmodule

// File: rtl/rb_digit_split.sv
module rb_digit_split
    import rbadd_pkg::*;
(
    input  rb_digit_t x,
    input  rb_digit_t y,
    input  logic      flag,
    output rb_digit_t interim,
    output rb_digit_t xfer
);
    pair_case_e kind;

    always_comb begin
        kind    = classify_pair(x, y);
        interim = RB_ZERO;
        xfer    = RB_ZERO;
        unique case (kind)
            PAIR_BOTH_POS: begin
                xfer    = RB_PLUS;
                interim = RB_ZERO;
            end
            PAIR_BOTH_NEG: begin
                xfer    = RB_MINUS;
                interim = RB_ZERO;
            end
            PAIR_ONE_POS: begin
                if (flag) begin
                    xfer    = RB_PLUS;
                    interim = RB_MINUS;
                end else begin
                    xfer    = RB_ZERO;
                    interim = RB_PLUS;
                end
            end
            PAIR_ONE_NEG: begin
                if (flag) begin
                    xfer    = RB_ZERO;
                    interim = RB_MINUS;
                end else begin
                    xfer    = RB_MINUS;
                    interim = RB_PLUS;
                end
            end
            default: begin
                xfer    = RB_ZERO;
                interim = RB_ZERO;
            end
        endcase
    end
endmodule

// File: rtl/rb_digit_merge.sv
module rb_digit_merge
    import rbadd_pkg::*;
(
    input  rb_digit_t interim,
    input  rb_digit_t xfer_in,
    output rb_digit_t digit
);
    // Opposite signs cancel; a zero passes the other term through.
    always_comb begin
        digit.pos = (interim.pos & ~xfer_in.neg) | (xfer_in.pos & ~interim.neg);
        digit.neg = (interim.neg & ~xfer_in.pos) | (xfer_in.neg & ~interim.pos);
    end
endmodule

// File: rtl/rb_adder.sv
module rb_adder
    import rbadd_pkg::*;
#(
    parameter int unsigned N_DIGITS = 8,
    parameter bit          REG_OUT  = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_DIGITS-1:0] a_pos,
    input  logic [N_DIGITS-1:0] a_neg,
    input  logic [N_DIGITS-1:0] b_pos,
    input  logic [N_DIGITS-1:0] b_neg,
    output logic [N_DIGITS:0]   sum_pos,
    output logic [N_DIGITS:0]   sum_neg
);
    localparam int unsigned RES_DIGITS = N_DIGITS + 1;

    rb_digit_t a_d     [N_DIGITS];
    rb_digit_t b_d     [N_DIGITS];
    rb_digit_t interim [N_DIGITS];
    rb_digit_t xfer    [N_DIGITS];
    rb_digit_t xfer_in [N_DIGITS];
    rb_digit_t merged  [N_DIGITS];
    logic      flag    [N_DIGITS];

    logic [RES_DIGITS-1:0] comb_pos;
    logic [RES_DIGITS-1:0] comb_neg;
    logic [N_DIGITS-1:0]   int_pos;
    logic [N_DIGITS-1:0]   int_neg;
    logic [N_DIGITS-1:0]   cin_pos;
    logic [N_DIGITS-1:0]   cin_neg;

    genvar gi;
    generate
        for (gi = 0; gi < N_DIGITS; gi++) begin : g_digit
            assign a_d[gi] = '{pos: a_pos[gi], neg: a_neg[gi]};
            assign b_d[gi] = '{pos: b_pos[gi], neg: b_neg[gi]};

            if (gi == 0) begin : g_first
                rb_lookback #(.IS_LSB(1'b1)) u_look (
                    .low_a (a_d[0]),
                    .low_b (b_d[0]),
                    .flag  (flag[0])
                );
                assign xfer_in[0] = RB_ZERO;
            end else begin : g_rest
                rb_lookback #(.IS_LSB(1'b0)) u_look (
                    .low_a (a_d[gi-1]),
                    .low_b (b_d[gi-1]),
                    .flag  (flag[gi])
                );
                assign xfer_in[gi] = xfer[gi-1];
            end

            rb_digit_split u_split (
                .x       (a_d[gi]),
                .y       (b_d[gi]),
                .flag    (flag[gi]),
                .interim (interim[gi]),
                .xfer    (xfer[gi])
            );

            rb_digit_merge u_merge (
                .interim (interim[gi]),
                .xfer_in (xfer_in[gi]),
                .digit   (merged[gi])
            );

            assign comb_pos[gi] = merged[gi].pos;
            assign comb_neg[gi] = merged[gi].neg;
            assign int_pos[gi]  = interim[gi].pos;
            assign int_neg[gi]  = interim[gi].neg;
            assign cin_pos[gi]  = xfer_in[gi].pos;
            assign cin_neg[gi]  = xfer_in[gi].neg;
        end
    endgenerate

    // Top result digit is the transfer leaving the highest position.
    assign comb_pos[N_DIGITS] = xfer[N_DIGITS-1].pos;
    assign comb_neg[N_DIGITS] = xfer[N_DIGITS-1].neg;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    sum_pos <= '0;
                    sum_neg <= '0;
                end else begin
                    sum_pos <= comb_pos;
                    sum_neg <= comb_neg;
                end
            end

            AST_RESET_CLEARS: assert property (@(posedge clk)
                rst |=> ((sum_pos | sum_neg) == '0)); // R9
        end else begin : g_comb
            assign sum_pos = comb_pos;
            assign sum_neg = comb_neg;
        end
    endgenerate

    function automatic longint signed digits_value(
        input logic [RES_DIGITS-1:0] p,
        input logic [RES_DIGITS-1:0] n
    );
        longint signed acc;
        acc = 0;
        for (int k = RES_DIGITS - 1; k >= 0; k--) begin
            acc = acc * 2 + longint'(p[k]) - longint'(n[k]);
        end
        return acc;
    endfunction

    AST_OPERAND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ((a_pos & a_neg) | (b_pos & b_neg)) == '0); // R1

    AST_NO_ILLEGAL_DIGIT: assert property (@(posedge clk) disable iff (rst)
        (sum_pos & sum_neg) == '0); // R2

    AST_SUM_VALUE: assert property (@(posedge clk) disable iff (rst)
        digits_value(comb_pos, comb_neg) ==
        digits_value({1'b0, a_pos}, {1'b0, a_neg}) +
        digits_value({1'b0, b_pos}, {1'b0, b_neg})); // R3

    AST_NO_COLLISION: assert property (@(posedge clk) disable iff (rst)
        ((int_pos & cin_pos) | (int_neg & cin_neg)) == '0); // R8

    AST_TOP_TRANSFER: assert property (@(posedge clk) disable iff (rst)
        (a_pos[N_DIGITS-1] & b_pos[N_DIGITS-1]) |->
        (comb_pos[N_DIGITS] & ~comb_neg[N_DIGITS])); // R7

endmodule

// File: tb/rb_adder_tb_top.sv
module rb_adder_tb_top;
    localparam int  NW         = 8;
    localparam int  NS         = 3;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic [NW-1:0] a_pos = '0, a_neg = '0, b_pos = '0, b_neg = '0;
    logic [NW:0]   sum_pos, sum_neg;

    logic [NS-1:0] sa_pos = '0, sa_neg = '0, sb_pos = '0, sb_neg = '0;
    logic [NS:0]   ssum_pos, ssum_neg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    longint exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rb_adder #(.N_DIGITS(NW), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst),
        .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
        .sum_pos(sum_pos), .sum_neg(sum_neg)
    );

    rb_adder #(.N_DIGITS(NS), .REG_OUT(1'b0)) dut_small_i (
        .clk(clk), .rst(rst),
        .a_pos(sa_pos), .a_neg(sa_neg), .b_pos(sb_pos), .b_neg(sb_neg),
        .sum_pos(ssum_pos), .sum_neg(ssum_neg)
    );

    function automatic longint vec_value(input logic [63:0] p, input logic [63:0] n, input int w);
        longint acc = 0;
        for (int k = w - 1; k >= 0; k--) acc = acc * 2 + longint'(p[k]) - longint'(n[k]);
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Drive at a falling edge, then check the registered result at the next falling edge.
    task automatic apply(input logic [NW-1:0] ap, an, bp, bn);
        longint expv;
        logic [NW:0] illegal;
        a_pos = ap; a_neg = an; b_pos = bp; b_neg = bn;
        exp_q.push_back(vec_value(64'(ap), 64'(an), NW) + vec_value(64'(bp), 64'(bn), NW));
        @(posedge clk);
        @(negedge clk);
        expv = exp_q.pop_front();
        check(vec_value(64'(sum_pos), 64'(sum_neg), NW + 1) == expv, "R3/R9", "sum value",
              vec_value(64'(sum_pos), 64'(sum_neg), NW + 1), expv);
        illegal = sum_pos & sum_neg;
        check(illegal == '0, "R2", "illegal digit mask", longint'(illegal), 0);
    endtask

    task automatic check_digits(input string req, input logic [NW:0] ep, en);
        check(sum_pos == ep, req, "plus bits", longint'(sum_pos), longint'(ep));
        check(sum_neg == en, req, "minus bits", longint'(sum_neg), longint'(en));
    endtask

    task automatic rand_digits(output logic [NW-1:0] p, output logic [NW-1:0] n);
        p = '0; n = '0;
        for (int k = 0; k < NW; k++) begin
            int r = int'($urandom_range(0, 2));
            if (r == 1) p[k] = 1'b1;
            else if (r == 2) n[k] = 1'b1;
        end
    endtask

    function automatic void small_digits(input int code, output logic [NS-1:0] p, output logic [NS-1:0] n);
        int c = code;
        p = '0; n = '0;
        for (int k = 0; k < NS; k++) begin
            if (c % 3 == 1) p[k] = 1'b1;
            else if (c % 3 == 2) n[k] = 1'b1;
            c = c / 3;
        end
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0] rp1, rn1, rp2, rn2;
        logic [NS-1:0] xp, xn, yp, yn;
        a_pos = 8'hFF;
        b_pos = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset holds the registered result at zero despite nonzero operands.
        check((sum_pos | sum_neg) == '0, "R9", "reset result", longint'(sum_pos | sum_neg), 0);
        rst = 1'b0;

        // R9: one-cycle latency; change operands and confirm the old result is shown first.
        a_pos = 8'h05; a_neg = '0; b_pos = '0; b_neg = '0;
        @(posedge clk);
        #1;
        a_pos = 8'h00;
        @(negedge clk);
        check(vec_value(64'(sum_pos), 64'(sum_neg), NW + 1) == 5, "R9", "latency hold",
              vec_value(64'(sum_pos), 64'(sum_neg), NW + 1), 5);

        // R4: all +1 plus all +1, all -1 plus all -1, +1 against -1, and zero plus zero.
        apply(8'hFF, 8'h00, 8'hFF, 8'h00); check_digits("R4", 9'h1FE, 9'h000);
        apply(8'h00, 8'hFF, 8'h00, 8'hFF); check_digits("R4", 9'h000, 9'h1FE);
        apply(8'hFF, 8'h00, 8'h00, 8'hFF); check_digits("R4", 9'h000, 9'h000);
        apply(8'h00, 8'h00, 8'h00, 8'h00); check_digits("R4", 9'h000, 9'h000);

        // R5 with flag 1 at digit 0 (R7: digit-0 flag is 1).
        apply(8'h01, 8'h00, 8'h00, 8'h00); check_digits("R5", 9'h002, 9'h001);
        // R5 with flag 0: +1 at digit 1 above a -1 at digit 0.
        apply(8'h02, 8'h01, 8'h00, 8'h00); check_digits("R5", 9'h002, 9'h001);
        apply(8'h00, 8'h00, 8'h02, 8'h01); check_digits("R5", 9'h002, 9'h001);

        // R6 with flag 1, then flag 0.
        apply(8'h00, 8'h01, 8'h00, 8'h00); check_digits("R6", 9'h000, 9'h001);
        apply(8'h00, 8'h03, 8'h00, 8'h00); check_digits("R6", 9'h002, 9'h005);

        // R7: transfer out of the top position becomes the top result digit.
        apply(8'h80, 8'h00, 8'h80, 8'h00); check_digits("R7", 9'h100, 9'h000);
        apply(8'h00, 8'h80, 8'h00, 8'h80); check_digits("R7", 9'h000, 9'h100);

        // R3: random operands at the default width.
        for (int t = 0; t < 2000; t++) begin
            rand_digits(rp1, rn1);
            rand_digits(rp2, rn2);
            apply(rp1, rn1, rp2, rn2);
        end

        // R3/R2: exhaustive legal operands on the combinational small instance.
        for (int i = 0; i < 27; i++) begin
            for (int j = 0; j < 27; j++) begin
                longint expv;
                longint actv;
                small_digits(i, xp, xn);
                small_digits(j, yp, yn);
                @(negedge clk);
                sa_pos = xp; sa_neg = xn; sb_pos = yp; sb_neg = yn;
                #1;
                expv = vec_value(64'(xp), 64'(xn), NS) + vec_value(64'(yp), 64'(yn), NS);
                actv = vec_value(64'(ssum_pos), 64'(ssum_neg), NS + 1);
                check(actv == expv, "R3", "small exhaustive value", actv, expv);
                check((ssum_pos & ssum_neg) == '0, "R2", "small illegal digit",
                      longint'(ssum_pos & ssum_neg), 0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule